// File: doc/BRIEF.md
# Character-Synchronous Preamble and Underrun-Fill Transmit Sequencer

This block is the character-level transmit sequencer of a byte-synchronous serial link. It takes data characters from a ready/valid source and drives one serial line bit. Every bit moves on a one-cycle bit-clock enable. When a frame is started, it can first send a sync preamble. The preamble is always the whole 16-bit sync register, sent bit 0 first. After the preamble come the frame's data characters, each sent bit 0 first. The frame closes after the character the source marked as last. The line then rests high.

If the source has no character ready at a character boundary inside a frame, the sequencer fills the gap on its own. In transparent mode it sends escape/sync pairs: the escape character, then the sync fill character. It always finishes a pair before it takes new data. In normal mode it sends plain sync fill characters. The escape and sync values are sent exactly as programmed, so a 7-bit-plus-parity link stores its parity bit inside those values.

Top module: `bisync_tx_seq`

## Requirements
- R1: While reset is held and after reset is released with no stimulus, `tx_bit` is 1, `data_ready` is 0 and `busy` is 0.
- R2: `start_frame` while idle with `sync_len` non-zero starts the frame. The `sync_len` codes are 1 = 4-bit, 2 = 8-bit and 3 = 16-bit. All three send all 16 bits of `sync_pattern`, bit 0 first, one bit per `bit_en` cycle. Code 0 sends no preamble, and the first character is chosen in the start cycle.
- R3: Each character occupies `tx_bit` for exactly CHAR_W `bit_en` cycles, bit 0 first. `tx_bit` changes only on a clock edge where `bit_en` was 1.
- R4: `data_ready` is 1 only at a character boundary. A boundary is a cycle with `bit_en` = 1 while the final bit of the current character or preamble is on the line, or the start cycle when there is no preamble. A character is taken when `data_valid` and `data_ready` are both 1. The taken character's bits start on the following cycle.
- R5: In transparent mode, a boundary inside a frame with `data_valid` = 0 sends `dle_char`. That escape is followed by the sync fill character, which is `sync_pattern[7:0]`. Both are sent unmodified.
- R6: An escape character is always followed by the sync fill character. At the escape's final bit, `data_ready` stays 0 even if `data_valid` is 1.
- R7: Outside transparent mode, a boundary inside a frame with `data_valid` = 0 sends the sync fill character `sync_pattern[7:0]`.
- R8: After the final bit of a character taken with `data_last` = 1, the next `bit_en` cycle returns the block to idle. Idle means `busy` = 0 and `tx_bit` = 1.
- R9: `start_frame` while busy has no effect. `data_valid` while idle without `start_frame` is not taken: `data_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one line bit per high cycle |
| sync_len | input | 2 | Preamble select: 0 none, 1/2/3 send the full sync register |
| sync_pattern | input | SYNC_W | Sync register; low CHAR_W bits are the sync fill character |
| dle_char | input | CHAR_W | Escape character used in transparent fill |
| transparent | input | 1 | Selects escape/sync pair fill |
| start_frame | input | 1 | Starts a frame when idle |
| data_in | input | CHAR_W | Data character |
| data_valid | input | 1 | Source has a character |
| data_last | input | 1 | Character is the final one of the frame |
| data_ready | output | 1 | Sequencer takes a character this cycle |
| tx_bit | output | 1 | Serial line output |
| busy | output | 1 | A frame is in progress |

## Verification
The sharpest collision is when the source turns valid in the very cycle an escape character ends. At that moment pair completion and data acceptance both claim the boundary. The correct result is that the sync fill character goes out and `data_ready` stays low.

The bench provokes this with many transparent frames. These frames have randomly timed source gaps and a sparse random bit enable, and it counts how often the collision occurs. A behavioural queue model predicts every line bit, ready and busy value. This prediction is compared on every clock.

A second overlap puts a stray `start_frame` in the middle of a frame. The model expects it to change nothing.

// File: rtl/bisync_tx_pkg.sv
package bisync_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_ESC,
    ST_FILL
  } tx_state_t;

  typedef enum logic [1:0] {
    LD_PREAMBLE,
    LD_DATA,
    LD_ESC,
    LD_FILL
  } load_sel_t;

endpackage

// File: rtl/bisync_tx_charsel.sv
module bisync_tx_charsel
  import bisync_tx_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int SYNC_W = 16,
  localparam int CNT_W = $clog2(SYNC_W)
) (
  input  load_sel_t         sel,
  input  logic [SYNC_W-1:0] sync_pattern,
  input  logic [CHAR_W-1:0] data_in,
  input  logic [CHAR_W-1:0] dle_char,
  output logic [SYNC_W-1:0] load_word,
  output logic [CNT_W-1:0]  load_cnt
);

  localparam int PAD_W = SYNC_W - CHAR_W;
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(SYNC_W - 1);
  localparam logic [CNT_W-1:0] CHAR_LAST = CNT_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] chr;
  logic [SYNC_W-1:0] chr_ext;

  always_comb begin
    case (sel)
      LD_DATA: chr = data_in;
      LD_ESC:  chr = dle_char;
      default: chr = sync_pattern[CHAR_W-1:0];
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign chr_ext = {{PAD_W{1'b0}}, chr};
    end else begin : g_nopad
      assign chr_ext = chr;
    end
  endgenerate

  always_comb begin
    if (sel == LD_PREAMBLE) begin
      load_word = sync_pattern;
      load_cnt  = PRE_LAST;
    end else begin
      load_word = chr_ext;
      load_cnt  = CHAR_LAST;
    end
  end

endmodule

// File: rtl/bisync_tx_shifter.sv
module bisync_tx_shifter #(
  parameter int SYNC_W = 16,
  localparam int CNT_W = $clog2(SYNC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [SYNC_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_cnt,
  output logic              line_bit,
  output logic              last_bit
);

  logic [SYNC_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = load_word;
      cnt_d = load_cnt;
    end else if (shift) begin
      sh_d  = {1'b1, sh_q[SYNC_W-1:1]};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load || shift) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign line_bit = sh_q[0];
  assign last_bit = (cnt_q == '0);

  // R3: a shift never starts from an exhausted count
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |-> !last_bit);

endmodule

// File: rtl/bisync_tx_ctrl.sv
module bisync_tx_ctrl
  import bisync_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  logic      start_frame,
  input  logic [1:0] sync_len,
  input  logic      transparent,
  input  logic      data_valid,
  input  logic      data_last,
  input  logic      last_bit,
  output logic      load,
  output logic      shift,
  output load_sel_t sel,
  output logic      data_ready,
  output logic      busy
);

  tx_state_t st_q, st_d;
  logic      last_q, last_d;
  logic      pick;

  always_comb begin
    st_d   = st_q;
    last_d = last_q;
    load   = 1'b0;
    shift  = 1'b0;
    sel    = LD_PREAMBLE;
    pick   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_frame) begin
          if (sync_len != 2'd0) begin
            load = 1'b1;
            sel  = LD_PREAMBLE;
            st_d = ST_PRE;
          end else begin
            pick = 1'b1;
          end
        end
      end
      default: begin
        if (bit_en) begin
          if (!last_bit) begin
            shift = 1'b1;
          end else if (st_q == ST_DATA && last_q) begin
            st_d = ST_IDLE;
          end else if (st_q == ST_ESC) begin
            load = 1'b1;
            sel  = LD_FILL;
            st_d = ST_FILL;
          end else begin
            pick = 1'b1;
          end
        end
      end
    endcase
    if (pick) begin
      load = 1'b1;
      if (data_valid) begin
        sel    = LD_DATA;
        st_d   = ST_DATA;
        last_d = data_last;
      end else if (transparent) begin
        sel  = LD_ESC;
        st_d = ST_ESC;
      end else begin
        sel  = LD_FILL;
        st_d = ST_FILL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
    end
  end

  assign data_ready = pick;
  assign busy       = (st_q != ST_IDLE);

  // R4: acceptance only at an enable edge or a frame start
  assert_ready_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (bit_en || start_frame));

  // R6: escape end always moves on to the sync fill character
  assert_pair_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ESC && bit_en && last_bit) |=> (st_q == ST_FILL));

  // R6: no character is taken while an escape is on the line
  assert_esc_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ESC) |-> !data_ready);

  // R5: escape fill only entered in transparent mode
  assert_esc_transp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_ESC) |-> $past(transparent));

  // R9: no acceptance while idle without a start request
  assert_idle_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_frame) |-> !data_ready);

endmodule

// File: rtl/bisync_tx_seq.sv
module bisync_tx_seq
  import bisync_tx_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [1:0]        sync_len,
  input  logic [SYNC_W-1:0] sync_pattern,
  input  logic [CHAR_W-1:0] dle_char,
  input  logic              transparent,
  input  logic              start_frame,
  input  logic [CHAR_W-1:0] data_in,
  input  logic              data_valid,
  input  logic              data_last,
  output logic              data_ready,
  output logic              tx_bit,
  output logic              busy
);

  localparam int CNT_W = $clog2(SYNC_W);

  logic              load, shift, line_bit, last_bit;
  load_sel_t         sel;
  logic [SYNC_W-1:0] load_word;
  logic [CNT_W-1:0]  load_cnt;

  bisync_tx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .start_frame (start_frame),
    .sync_len    (sync_len),
    .transparent (transparent),
    .data_valid  (data_valid),
    .data_last   (data_last),
    .last_bit    (last_bit),
    .load        (load),
    .shift       (shift),
    .sel         (sel),
    .data_ready  (data_ready),
    .busy        (busy)
  );

  bisync_tx_charsel #(.CHAR_W(CHAR_W), .SYNC_W(SYNC_W)) u_sel (
    .sel          (sel),
    .sync_pattern (sync_pattern),
    .data_in      (data_in),
    .dle_char     (dle_char),
    .load_word    (load_word),
    .load_cnt     (load_cnt)
  );

  bisync_tx_shifter #(.SYNC_W(SYNC_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .shift     (shift),
    .load_word (load_word),
    .load_cnt  (load_cnt),
    .line_bit  (line_bit),
    .last_bit  (last_bit)
  );

  assign tx_bit = busy ? line_bit : 1'b1;

  // R3: the line holds its bit through cycles without an enable
  assert_hold_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> $stable(tx_bit));

  // R8: leaving a frame requires an enable edge
  assert_end_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_en));

endmodule

// File: tb/bisync_tx_seq_test.sv
module bisync_tx_seq_test;

  localparam int CHAR_W = 8;
  localparam int SYNC_W = 16;
  localparam int LIMIT  = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bit_en;
  logic [1:0]        sync_len;
  logic [SYNC_W-1:0] sync_pattern;
  logic [CHAR_W-1:0] dle_char;
  logic              transparent;
  logic              start_frame;
  logic [CHAR_W-1:0] data_in;
  logic              data_valid;
  logic              data_last;
  logic              data_ready;
  logic              tx_bit;
  logic              busy;

  always #2 clk = ~clk;

  bisync_tx_seq #(.CHAR_W(CHAR_W), .SYNC_W(SYNC_W)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_len(sync_len),
    .sync_pattern(sync_pattern), .dle_char(dle_char), .transparent(transparent),
    .start_frame(start_frame), .data_in(data_in), .data_valid(data_valid),
    .data_last(data_last), .data_ready(data_ready), .tx_bit(tx_bit), .busy(busy)
  );

  // reference model: 0 idle, 1 preamble, 2 data, 3 escape, 4 sync fill
  int  m_st;
  bit  m_q[$];
  bit  m_last;
  bit  m_pick;
  bit  took;
  int  pair_corner;
  int  vectors;
  int  miscompares;
  int  cycles;
  bit  wd;

  logic [CHAR_W:0] src[$];
  int  en_pct, gap_pct, gap_left;
  bit  start_req;

  function automatic bit m_ready();
    if (m_st == 0) return start_frame && (sync_len == 2'd0);
    return bit_en && (m_q.size() == 1) && (m_st != 3) && !(m_st == 2 && m_last);
  endfunction

  function automatic bit m_tx();
    if (m_st == 0) return 1'b1;
    return m_q[0];
  endfunction

  task automatic push_bits(input logic [SYNC_W-1:0] w, input int n);
    for (int i = 0; i < n; i++) m_q.push_back(w[i]);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_q.delete(); m_last = 0; took = 0;
    end else begin
      m_pick = 0;
      took   = m_ready() && data_valid;
      if (m_st == 0) begin
        if (start_frame) begin
          if (sync_len != 2'd0) begin
            m_q.delete(); push_bits(sync_pattern, SYNC_W); m_st = 1;
          end else m_pick = 1;
        end
      end else if (bit_en) begin
        if (m_q.size() > 1) void'(m_q.pop_front());
        else if (m_st == 2 && m_last) begin m_st = 0; m_q.delete(); end
        else if (m_st == 3) begin
          if (data_valid) pair_corner++;
          m_q.delete(); push_bits({8'h00, sync_pattern[7:0]}, CHAR_W); m_st = 4;
        end else m_pick = 1;
      end
      if (m_pick) begin
        m_q.delete();
        if (data_valid) begin
          push_bits({8'h00, data_in}, CHAR_W); m_st = 2; m_last = data_last;
        end else if (transparent) begin
          push_bits({8'h00, dle_char}, CHAR_W); m_st = 3;
        end else begin
          push_bits({8'h00, sync_pattern[7:0]}, CHAR_W); m_st = 4;
        end
      end
    end
  end

  function automatic string tag_of();
    case (m_st)
      0: return rst_n ? "R8" : "R1";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      default: return transparent ? "R6" : "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cycles, act, exp);
    end
  endtask

  task automatic compare();
    check(tag_of(), tx_bit, m_tx(), "tx_bit");
    check((m_st == 3) ? "R6" : (m_st == 0 ? "R9" : "R4"), data_ready, m_ready(), "data_ready");
    check("R8", busy, (m_st != 0), "busy");
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (cycles > LIMIT) wd = 1;
    compare();
    if (took && src.size() > 0) void'(src.pop_front());
    took = 0;
    bit_en      = (($urandom % 100) < en_pct);
    start_frame = start_req;
    start_req   = 0;
    if (gap_left > 0) gap_left--;
    else if (($urandom % 100) < gap_pct) gap_left = 1 + ($urandom % 24);
    data_valid = (src.size() > 0) && (gap_left == 0);
    if (src.size() > 0) {data_last, data_in} = src[0];
    else {data_last, data_in} = '0;
  endtask

  task automatic run_frame(input int n, input logic [1:0] len, input bit tr,
                           input int en, input int gap);
    sync_len = len; transparent = tr; en_pct = en; gap_pct = gap;
    for (int i = 0; i < n; i++)
      src.push_back({(i == n - 1), 8'($urandom)});
    // R9: valid source while idle is not taken
    for (int i = 0; i < 3; i++) tick();
    start_req = 1;
    tick();
    tick();
    while (m_st != 0 && !wd) begin
      // R9: stray start mid-frame, only away from a frame end
      if (m_q.size() > 2 && ($urandom % 100) < 3) start_req = 1;
      tick();
    end
    check("R8", busy, 1'b0, "busy after frame");
    check("R8", tx_bit, 1'b1, "line after frame");
    check("R8", logic'(src.size() == 0), 1'b1, "source drained");
  endtask

  initial begin
    rst_n = 0; bit_en = 0; sync_len = 2'd3; sync_pattern = 16'hA5C3;
    dle_char = 8'h10; transparent = 0; start_frame = 0;
    data_in = '0; data_valid = 0; data_last = 0;
    vectors = 0; miscompares = 0; cycles = 0; wd = 0; pair_corner = 0;
    en_pct = 100; gap_pct = 0; gap_left = 0; start_req = 0;
    repeat (3) begin
      @(negedge clk);
      check("R1", tx_bit, 1'b1, "reset tx");
      check("R1", data_ready, 1'b0, "reset ready");
      check("R1", busy, 1'b0, "reset busy");
    end
    rst_n = 1;
    tick(); tick();
    // R2 preamble with each non-zero length, R3 data, no gaps
    run_frame(3, 2'd3, 0, 100, 0);
    run_frame(2, 2'd1, 0, 100, 0);
    run_frame(2, 2'd2, 1, 100, 0);
    // R2 no preamble
    sync_pattern = 16'h3C96;
    run_frame(4, 2'd0, 0, 100, 0);
    // R7 plain sync fill, R5 escape pair fill
    run_frame(6, 2'd3, 0, 100, 8);
    run_frame(6, 2'd3, 1, 100, 8);
    // R3 sparse enable, R6 escape end colliding with resumed data
    for (int f = 0; f < 60 && !wd; f++) begin
      sync_pattern = 16'($urandom);
      dle_char     = 8'($urandom);
      run_frame(3 + ($urandom % 8), 2'($urandom), (f % 4) != 0,
                30 + ($urandom % 71), 5 + ($urandom % 15));
    end
    // R6 collision case provoked at least once
    check("R6", logic'(pair_corner > 0), 1'b1, "escape-end collision seen");
    if (wd) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule